// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core takes next. Each of its vector slots owns one request bit. A rising edge on the input routed to a slot sets that bit. On a slot that two sources share, a route bit picks which of the two inputs may do so. A per-slot mask bit and the core's global disable flag decide which pending slots may be accepted. When the core signals an instruction boundary, the lowest-numbered eligible slot wins. The block clears that slot's request bit, returns the slot's vector address and then steps through a fixed seven-cycle stacking and vector-fetch sequence.

A software break is held as a separate pending flag. It ignores the global disable flag and ranks below every maskable slot. The core reads and writes the request, mask and route registers over a simple register bus. Software may clear request bits but never set them. After reset the vector output holds the reset vector, which is the topmost address pair.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the request, mask and route registers read 0, `vector_o` is 16'hFFFE, and `accept_o`, `push_o`, `fetch_o` and `iflag_set_o` are 0.
- R2: A rising edge on the input routed to slot k sets request bit k at the next clock edge, whatever the slot's mask bit. The bit stays set while it is not accepted.
- R3: Bus address 2 is the route register. Only slots in `SHARED_MASK` (default 8'h81, slots 0 and 7) keep a written bit; other bits read 0. A shared slot takes edges from `src_alt_i[k]` when its route bit is 1 and from `src_pri_i[k]` when it is 0. The unrouted input has no effect, and an unshared slot always uses `src_pri_i[k]`.
- R4: A bus write to address 0 (request register) clears each request bit whose written bit is 0 and leaves bits written 1 unchanged. It never sets a bit.
- R5: A maskable slot is accepted only at a clock edge where `boundary_i` is 1, the sequencer is idle, its request bit and mask bit (bus address 1) are both 1, and `iflag_i` is 0.
- R6: When several slots are eligible, the lowest index is accepted. The others stay pending and are considered again at the next boundary.
- R7: The vector for slot k is 16'hFFFE - 2*(k+1). The break vector is 16'hFFFE - 2*(NSLOT+1), which is 16'hFFEC for 8 slots. `vector_o` holds the last value until the next acceptance.
- R8: The accepted slot's request bit reads 0 after the accepting edge.
- R9: A one-cycle pulse on `brk_i` sets a break flag. At a boundary the break is accepted even when `iflag_i` is 1, but only when no maskable slot is eligible. Accepting it clears the flag.
- R10: Counting the cycle after the accepting edge as A: `accept_o` is high in A. `push_o` is high in A+1, A+2 and A+3, with `push_sel_o` equal to 0 (PC high), 1 (PC low) and 2 (status) in that order. `fetch_o` is high in A+4 and A+5, with `fetch_hi_o` high only in A+5. `iflag_set_o` is high in A+4. A+6 is a quiet cycle, and a boundary strobe from A through A+6 is ignored.
- R11: When a new edge arrives in the same cycle as a clear of the same request bit, by bus write or by acceptance, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 request, 1 mask, 2 route |
| bus_wdata | input | NSLOT | Write data |
| bus_rdata | output | NSLOT | Read data of the addressed register (combinational) |
| src_pri_i | input | NSLOT | Primary request input of each slot |
| src_alt_i | input | NSLOT | Alternate request input (used on shared slots) |
| brk_i | input | 1 | Software break pulse |
| iflag_i | input | 1 | Global interrupt disable flag from the core |
| boundary_i | input | 1 | Instruction-boundary strobe |
| accept_o | output | 1 | Acceptance pulse, first step of the sequence |
| vector_o | output | VEC_W | Vector address of the accepted source |
| push_o | output | 1 | Stack push step |
| push_sel_o | output | 2 | What to push: 0 PC high, 1 PC low, 2 status |
| fetch_o | output | 1 | Vector fetch step |
| fetch_hi_o | output | 1 | Fetch of the vector's upper byte |
| iflag_set_o | output | 1 | Tells the core to set its disable flag |

## Verification
A request edge shows in the request register one edge after the input rises, and the bench reads the register at the following falling edge. The accept pulse and the new vector appear in the cycle after the boundary edge. The scoreboard monitor pops its expected vector only when it sees `accept_o` high at a falling edge. From that point it checks each of the six following cycles against the fixed step order of R10. A boundary strobe given while a sequence is running, or while the disable flag is set, leaves nothing in the queue. Any acceptance it caused would therefore be reported as unexpected.

// File: rtl/irqv_pkg.sv
// irqv_pkg: shared encodings of the vectored interrupt controller.
// Assumes: the register bus has four addresses; three are used.
package irqv_pkg;

    typedef enum logic [1:0] {
        REG_PEND  = 2'd0,
        REG_MASK  = 2'd1,
        REG_ROUTE = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PUSH_PC_HI  = 2'd0,
        PUSH_PC_LO  = 2'd1,
        PUSH_STATUS = 2'd2
    } push_kind_e;

endpackage

// File: rtl/irqv_req_bank.sv
// irqv_req_bank: edge detection, request bits, mask and route registers.
// Does: sets a request bit on a rising edge of the routed input, lets the
// bus clear (never set) request bits, and clears accepted bits.
// Assumes: inputs are already synchronous to clk; a new edge wins over
// any clear in the same cycle.
module irqv_req_bank
    import irqv_pkg::*;
#(
    parameter int unsigned          NSLOT       = 8,
    parameter logic [NSLOT-1:0]     SHARED_MASK = 'h81
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [NSLOT-1:0] bus_wdata,
    output logic [NSLOT-1:0] bus_rdata,
    input  logic [NSLOT-1:0] src_pri_i,
    input  logic [NSLOT-1:0] src_alt_i,
    input  logic [NSLOT-1:0] clr_i,
    output logic [NSLOT-1:0] pend_o,
    output logic [NSLOT-1:0] mask_o
);

    logic [NSLOT-1:0] pri_q, alt_q;
    logic [NSLOT-1:0] pend_q, pend_n, mask_q, route_q;
    logic [NSLOT-1:0] rise;
    logic             wr_pend;

    assign wr_pend = bus_we && (bus_addr == REG_PEND);

    // Input history; loaded with the live inputs in reset so no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= src_pri_i;
            alt_q <= src_alt_i;
        end else begin
            pri_q <= src_pri_i;
            alt_q <= src_alt_i;
        end
    end

    // Per-slot edge source: shared slots follow their route bit.
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        if (SHARED_MASK[k]) begin : g_shared
            assign rise[k] = route_q[k] ? (src_alt_i[k] & ~alt_q[k])
                                        : (src_pri_i[k] & ~pri_q[k]);
        end else begin : g_single
            assign rise[k] = src_pri_i[k] & ~pri_q[k];
        end
    end

    // Next request bits: bus clear, accept clear, then new edges on top.
    always_comb begin
        pend_n = pend_q;
        if (wr_pend) pend_n = pend_n & bus_wdata;
        pend_n = pend_n & ~clr_i;
        pend_n = pend_n | rise;
    end

    // Request, mask and route register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= '0;
            route_q <= '0;
        end else begin
            pend_q <= pend_n;
            if (bus_we && (bus_addr == REG_MASK))  mask_q  <= bus_wdata;
            if (bus_we && (bus_addr == REG_ROUTE)) route_q <= bus_wdata & SHARED_MASK;
        end
    end

    // Read mux of the register bus.
    always_comb begin
        case (bus_addr)
            REG_PEND:  bus_rdata = pend_q;
            REG_MASK:  bus_rdata = mask_q;
            REG_ROUTE: bus_rdata = route_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    // R4: a bus write with no edge cannot raise any request bit.
    p_sw_never_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && (rise == '0)) |=> ((pend_q & ~$past(pend_q)) == '0));

    // R2 and R11: every detected edge leaves its request bit set.
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

endmodule

// File: rtl/irqv_prio_pick.sv
// irqv_prio_pick: fixed-priority selection, lowest index wins.
// Assumes: cand_i already combines request, mask and disable flag.
module irqv_prio_pick #(
    parameter int unsigned NSLOT  = 8,
    localparam int unsigned SIDX_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOT-1:0]  cand_i,
    output logic              any_o,
    output logic [SIDX_W-1:0] idx_o,
    output logic [NSLOT-1:0]  onehot_o
);

    assign any_o = |cand_i;

    // Scan from the top down so the lowest set index is kept.
    always_comb begin
        idx_o = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = SIDX_W'(i);
        end
    end

    // Isolate the lowest set bit for the clear mask.
    assign onehot_o = cand_i & (~cand_i + NSLOT'(1));

    // R6: the index and the clear mask name the same winning slot.
    p_pick_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (onehot_o[idx_o] && $onehot(onehot_o)));

endmodule

// File: rtl/irqv_seq.sv
// irqv_seq: acceptance decision, break flag and the stacking sequence.
// Does: accepts at a boundary when idle, produces the vector, then walks
// through the push and fetch steps.
// Assumes: SEQ_LEN >= 7; step 0 is acceptance, 1..3 pushes, 4..5 fetches.
module irqv_seq
    import irqv_pkg::*;
#(
    parameter int unsigned         NSLOT   = 8,
    parameter int unsigned         VEC_W   = 16,
    parameter logic [VEC_W-1:0]    VEC_TOP = 16'hFFFE,
    parameter int unsigned         SEQ_LEN = 7,
    localparam int unsigned        SIDX_W  = $clog2(NSLOT),
    localparam int unsigned        STEP_W  = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              iflag_i,
    input  logic              brk_i,
    input  logic              cand_any_i,
    input  logic [SIDX_W-1:0] cand_idx_i,
    input  logic [NSLOT-1:0]  cand_onehot_i,
    output logic [NSLOT-1:0]  clr_o,
    output logic              accept_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic              push_o,
    output logic [1:0]        push_sel_o,
    output logic              fetch_o,
    output logic              fetch_hi_o,
    output logic              iflag_set_o
);

    localparam logic [STEP_W-1:0] ST_ACC = STEP_W'(0);
    localparam logic [STEP_W-1:0] ST_PCH = STEP_W'(1);
    localparam logic [STEP_W-1:0] ST_PCL = STEP_W'(2);
    localparam logic [STEP_W-1:0] ST_PS  = STEP_W'(3);
    localparam logic [STEP_W-1:0] ST_FLO = STEP_W'(4);
    localparam logic [STEP_W-1:0] ST_FHI = STEP_W'(5);
    localparam logic [STEP_W-1:0] ST_END = STEP_W'(SEQ_LEN - 1);
    localparam logic [VEC_W-1:0]  BRK_VEC = VEC_TOP - VEC_W'(2 * (NSLOT + 1));

    logic              busy_q, brk_pend_q, brk_taken_q;
    logic [STEP_W-1:0] step_q;
    logic [VEC_W-1:0]  vec_q;
    logic              take_irq, take_brk;

    // Acceptance: maskable slots first, the break only when none is eligible.
    assign take_irq = boundary_i && !busy_q && cand_any_i;
    assign take_brk = boundary_i && !busy_q && !cand_any_i && brk_pend_q;
    assign clr_o    = take_irq ? cand_onehot_i : '0;

    // Break flag: a pulse arms it, acceptance of the break disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_pend_q <= 1'b0;
        else        brk_pend_q <= (brk_pend_q && !take_brk) || brk_i;
    end

    // Step counter and vector register of the running sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            step_q      <= ST_ACC;
            vec_q       <= VEC_TOP;
            brk_taken_q <= 1'b0;
        end else if (take_irq || take_brk) begin
            busy_q      <= 1'b1;
            step_q      <= ST_ACC;
            brk_taken_q <= take_brk;
            vec_q       <= take_brk ? BRK_VEC
                         : VEC_TOP - ((VEC_W'(cand_idx_i) + VEC_W'(1)) << 1);
        end else if (busy_q) begin
            if (step_q == ST_END) begin
                busy_q <= 1'b0;
                step_q <= ST_ACC;
            end else begin
                step_q <= step_q + STEP_W'(1);
            end
        end
    end

    // Step decode into the sequencing outputs.
    always_comb begin
        accept_o    = busy_q && (step_q == ST_ACC);
        push_o      = busy_q && ((step_q == ST_PCH) || (step_q == ST_PCL) || (step_q == ST_PS));
        fetch_o     = busy_q && ((step_q == ST_FLO) || (step_q == ST_FHI));
        fetch_hi_o  = busy_q && (step_q == ST_FHI);
        iflag_set_o = busy_q && (step_q == ST_FLO);
        if (step_q == ST_PCL)     push_sel_o = PUSH_PC_LO;
        else if (step_q == ST_PS) push_sel_o = PUSH_STATUS;
        else                      push_sel_o = PUSH_PC_HI;
    end

    assign vector_o = vec_q;

    // R5: every acceptance follows a boundary strobe.
    p_accept_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(boundary_i));

    // R5 and R9: only the break may be accepted while the disable flag is set.
    p_mask_honours_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !brk_taken_q) |-> !$past(iflag_i));

    // R10: a running sequence advances one step per cycle.
    p_seq_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (step_q != ST_END)) |=> (busy_q && (step_q == $past(step_q) + STEP_W'(1))));

    // R10: the disable flag is set only after the status push.
    p_flag_after_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && (push_sel_o == PUSH_STATUS)) |=> (iflag_set_o && fetch_o && !fetch_hi_o));

endmodule

// File: rtl/irq_vec_ctrl.sv
// irq_vec_ctrl: top of the vectored fixed-priority interrupt controller.
// Does: wires the request bank, the priority pick and the sequencer; the
// disable flag gates maskable candidates here.
// Assumes: boundary_i is a one-cycle strobe per instruction boundary.
module irq_vec_ctrl #(
    parameter int unsigned      NSLOT       = 8,
    parameter int unsigned      VEC_W       = 16,
    parameter logic [VEC_W-1:0] VEC_TOP     = 16'hFFFE,
    parameter logic [NSLOT-1:0] SHARED_MASK = 'h81,
    parameter int unsigned      SEQ_LEN     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [NSLOT-1:0] bus_wdata,
    output logic [NSLOT-1:0] bus_rdata,
    input  logic [NSLOT-1:0] src_pri_i,
    input  logic [NSLOT-1:0] src_alt_i,
    input  logic             brk_i,
    input  logic             iflag_i,
    input  logic             boundary_i,
    output logic             accept_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             push_o,
    output logic [1:0]       push_sel_o,
    output logic             fetch_o,
    output logic             fetch_hi_o,
    output logic             iflag_set_o
);

    localparam int unsigned SIDX_W = $clog2(NSLOT);

    logic [NSLOT-1:0]  pend, mask, cand, cand_onehot, clr;
    logic              cand_any;
    logic [SIDX_W-1:0] cand_idx;

    // Eligible slots: pending, unmasked, disable flag clear.
    assign cand = pend & mask & {NSLOT{!iflag_i}};

    irqv_req_bank #(.NSLOT(NSLOT), .SHARED_MASK(SHARED_MASK)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_pri_i (src_pri_i),
        .src_alt_i (src_alt_i),
        .clr_i     (clr),
        .pend_o    (pend),
        .mask_o    (mask)
    );

    irqv_prio_pick #(.NSLOT(NSLOT)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand_i   (cand),
        .any_o    (cand_any),
        .idx_o    (cand_idx),
        .onehot_o (cand_onehot)
    );

    irqv_seq #(.NSLOT(NSLOT), .VEC_W(VEC_W), .VEC_TOP(VEC_TOP), .SEQ_LEN(SEQ_LEN)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .boundary_i    (boundary_i),
        .iflag_i       (iflag_i),
        .brk_i         (brk_i),
        .cand_any_i    (cand_any),
        .cand_idx_i    (cand_idx),
        .cand_onehot_i (cand_onehot),
        .clr_o         (clr),
        .accept_o      (accept_o),
        .vector_o      (vector_o),
        .push_o        (push_o),
        .push_sel_o    (push_sel_o),
        .fetch_o       (fetch_o),
        .fetch_hi_o    (fetch_hi_o),
        .iflag_set_o   (iflag_set_o)
    );

    // R8: an accepted slot's request bit is gone after the accepting edge.
    p_accept_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr != '0) && ((clr & (src_pri_i | src_alt_i)) == '0)) |=> ((pend & $past(clr)) == '0));

endmodule

// File: tb/irq_vec_ctrl_test.sv
// Scoreboard bench: driver tasks queue expected vectors, a monitor pops
// them when accept_o is seen and then checks the step sequence.
module irq_vec_ctrl_test;

    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [NS-1:0] bus_wdata = '0;
    logic [NS-1:0] bus_rdata;
    logic [NS-1:0] src_pri = '0;
    logic [NS-1:0] src_alt = '0;
    logic          brk = 1'b0;
    logic          iflag = 1'b0;
    logic          boundary = 1'b0;
    logic          accept_o, push_o, fetch_o, fetch_hi_o, iflag_set_o;
    logic [15:0]   vector_o;
    logic [1:0]    push_sel_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int mstep = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    irq_vec_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pri_i(src_pri),
        .src_alt_i(src_alt), .brk_i(brk), .iflag_i(iflag), .boundary_i(boundary),
        .accept_o(accept_o), .vector_o(vector_o), .push_o(push_o),
        .push_sel_o(push_sel_o), .fetch_o(fetch_o), .fetch_hi_o(fetch_hi_o),
        .iflag_set_o(iflag_set_o)
    );

    function automatic logic [15:0] slot_vec(int k);
        return 16'hFFFE - 16'(2 * (k + 1));
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_wr(logic [1:0] a, logic [NS-1:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic chk_reg(logic [1:0] a, logic [NS-1:0] exp, string req);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, "register read", bus_rdata, exp);
    endtask

    task automatic pulse(logic [NS-1:0] pri, logic [NS-1:0] alt);
        src_pri = pri; src_alt = alt;
        tick();
        src_pri = '0; src_alt = '0;
        tick();
    endtask

    task automatic strobe();
        boundary = 1'b1;
        tick();
        boundary = 1'b0;
    endtask

    task automatic settle();
        repeat (8) tick();
    endtask

    // Monitor: pops the expected vector on accept, then checks R10 steps.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mstep != 0) begin
                check(!accept_o, "R10", "accept inside sequence", accept_o, 0);
                case (mstep)
                    1: check(push_o && push_sel_o == 2'd0 && !fetch_o, "R10", "PC high push", {push_o, push_sel_o}, 3'b100);
                    2: check(push_o && push_sel_o == 2'd1 && !fetch_o, "R10", "PC low push", {push_o, push_sel_o}, 3'b101);
                    3: check(push_o && push_sel_o == 2'd2 && !iflag_set_o, "R10", "status push", {push_o, push_sel_o}, 3'b110);
                    4: check(fetch_o && !fetch_hi_o && iflag_set_o && !push_o, "R10", "fetch low", {fetch_o, fetch_hi_o, iflag_set_o}, 3'b101);
                    5: check(fetch_o && fetch_hi_o && !iflag_set_o, "R10", "fetch high", {fetch_o, fetch_hi_o, iflag_set_o}, 3'b110);
                    default: check(!push_o && !fetch_o && !iflag_set_o, "R10", "quiet step", {push_o, fetch_o, iflag_set_o}, 0);
                endcase
                mstep = (mstep == 6) ? 0 : mstep + 1;
            end else if (accept_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected acceptance vector", vector_o, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(vector_o == e, "R7", "accepted vector", vector_o, e);
                end
                mstep = 1;
            end else begin
                check(!push_o && !fetch_o && !iflag_set_o, "R10", "idle outputs", {push_o, fetch_o, iflag_set_o}, 0);
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk_reg(2'd0, '0, "R1");
        chk_reg(2'd1, '0, "R1");
        chk_reg(2'd2, '0, "R1");
        check(vector_o == 16'hFFFE, "R1", "reset vector", vector_o, 16'hFFFE);
        check(!accept_o && !push_o && !fetch_o && !iflag_set_o, "R1", "reset outputs", accept_o, 0);

        // R2: masked slot still latches, and is not accepted
        pulse(8'h04, 8'h00);
        chk_reg(2'd0, 8'h04, "R2");
        strobe(); settle();
        chk_reg(2'd0, 8'h04, "R2 stays pending");

        // R5: disable flag blocks, no strobe means no acceptance
        bus_wr(2'd1, 8'h04);
        iflag = 1'b1;
        strobe(); settle();
        chk_reg(2'd0, 8'h04, "R5");
        iflag = 1'b0;
        repeat (4) tick();
        chk_reg(2'd0, 8'h04, "R5 waits for strobe");
        exp_q.push_back(slot_vec(2));
        strobe();
        chk_reg(2'd0, 8'h00, "R8");
        settle();

        // R6: lowest index wins, other stays pending
        bus_wr(2'd1, 8'hFF);
        pulse(8'h28, 8'h00);
        exp_q.push_back(slot_vec(3));
        strobe(); settle();
        chk_reg(2'd0, 8'h20, "R6");
        exp_q.push_back(slot_vec(5));
        strobe(); settle();
        chk_reg(2'd0, 8'h00, "R6");

        // R4: software clears only
        bus_wr(2'd1, 8'h00);
        pulse(8'h12, 8'h00);
        chk_reg(2'd0, 8'h12, "R2");
        bus_wr(2'd0, 8'hEF);
        chk_reg(2'd0, 8'h02, "R4");
        bus_wr(2'd0, 8'hFF);
        chk_reg(2'd0, 8'h02, "R4");
        bus_wr(2'd0, 8'h00);
        chk_reg(2'd0, 8'h00, "R4");

        // R3: route register and shared slots
        bus_wr(2'd2, 8'hFF);
        chk_reg(2'd2, 8'h81, "R3");
        pulse(8'h01, 8'h00);
        chk_reg(2'd0, 8'h00, "R3 unrouted input");
        pulse(8'h00, 8'h01);
        chk_reg(2'd0, 8'h01, "R3 routed alternate");
        pulse(8'h00, 8'h08);
        chk_reg(2'd0, 8'h01, "R3 unshared alternate");
        pulse(8'h08, 8'h00);
        chk_reg(2'd0, 8'h09, "R3 unshared primary");
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd2, 8'h00);
        pulse(8'h00, 8'h01);
        chk_reg(2'd0, 8'h00, "R3 route cleared");

        // R9: break ignores the disable flag
        bus_wr(2'd1, 8'hFF);
        iflag = 1'b1;
        brk = 1'b1; tick(); brk = 1'b0; tick();
        exp_q.push_back(16'hFFEC);
        strobe(); settle();
        iflag = 1'b0;
        // R9: break ranks below a maskable slot
        pulse(8'h40, 8'h00);
        brk = 1'b1; tick(); brk = 1'b0; tick();
        exp_q.push_back(slot_vec(6));
        exp_q.push_back(16'hFFEC);
        strobe(); settle();
        strobe(); settle();
        strobe(); settle();

        // R11: edge beats a bus clear in the same cycle
        bus_wr(2'd1, 8'h00);
        src_pri = 8'h10;
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h00;
        tick();
        bus_we = 1'b0; src_pri = 8'h00;
        tick();
        chk_reg(2'd0, 8'h10, "R11");
        // R11: edge beats the acceptance clear in the same cycle
        bus_wr(2'd1, 8'h10);
        exp_q.push_back(slot_vec(4));
        boundary = 1'b1; src_pri = 8'h10;
        tick();
        boundary = 1'b0; src_pri = 8'h00;
        chk_reg(2'd0, 8'h10, "R11");
        settle();
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'h00);

        // R10: strobe during a running sequence is ignored
        bus_wr(2'd1, 8'hFF);
        pulse(8'h06, 8'h00);
        exp_q.push_back(slot_vec(1));
        strobe();
        tick(); tick();
        strobe();
        settle();
        chk_reg(2'd0, 8'h04, "R10 ignored strobe");
        check(vector_o == slot_vec(1), "R7", "vector held", vector_o, slot_vec(1));
        exp_q.push_back(slot_vec(2));
        strobe(); settle();

        check(exp_q.size() == 0, "R5", "missing acceptances", exp_q.size(), 0);
        done = 1'b1;
        report();
        $finish;
    end

endmodule